// File: doc/BRIEF.md
# Memory-Mapped Configuration Access Translator

This block sits on the host's memory request path and turns ordinary loads and stores into device configuration requests. A programmable base register places a 256 MB window on a 256 MB boundary of the 32-bit address space. A host request whose top four address bits match that base, while the window is enabled, is taken by the translator. Its offset inside the window is split into the target's bus, device, function, extended register and dword register numbers. The request is then sent on a valid/ready configuration channel, together with its direction, byte enables and write data.

Each function has 4 KB of configuration space. Offsets 0x000 to 0x0FF form the legacy-compatible region, and offsets 0x100 to 0xFFF form the extended region. A configuration access must be a single aligned dword access that is not locked. Any other access gets an immediate error response with all-ones data, and nothing is sent downstream. Only one configuration request is in flight at a time. Requests outside the window are steered to the ordinary memory path without change.

Top module: `cfg_window_xlate`

## Requirements
- R1: After reset the base register reads 0 and the window is disabled. A write keeps only address bits [31:28] (the window base) and bit 0 (the enable), and every other bit reads back as 0.
- R2: A request is a hit only when the enable bit is 1 and h_req_addr[31:28] equals the base. On a miss, mem_req_valid follows h_req_valid, h_req_ready follows mem_req_ready, and no configuration request is issued.
- R3: A hit sends c_req_bus = addr[27:20], c_req_dev = addr[19:15], c_req_fn = addr[14:12], c_req_ext = addr[11:8] and c_req_dw = addr[7:2].
- R4: Offsets 0x000 to 0x0FF inside the window give c_req_ext = 0, and offsets from 0x100 upward give the non-zero extended number taken from bits [11:8].
- R5: The direction, the byte enables and the write data of a hit reach c_req_write, c_req_be and c_req_wdata unchanged.
- R6: A hit whose addr[1:0] is not 0 gets h_rsp_valid with h_rsp_err = 1 and h_rsp_data = 0xFFFFFFFF in the cycle after it is accepted, and no configuration request is issued.
- R7: A hit with h_req_size = 3 (eight bytes; sizes 0, 1 and 2 mean 1, 2 and 4 bytes) is rejected in the same way as in R6.
- R8: A hit with h_req_lock = 1 is rejected in the same way as in R6.
- R9: c_req_valid rises in the cycle after a legal hit is accepted. It stays high with stable fields until c_req_ready is seen. For hits, h_req_ready stays low from acceptance until the response cycle has ended.
- R10: When c_cpl_valid arrives after the request handshake, h_rsp_valid pulses high for exactly one cycle in the next cycle. It carries h_rsp_data = c_cpl_data and h_rsp_err = c_cpl_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the base register |
| reg_wdata | input | 32 | Base register write value |
| reg_rdata | output | 32 | Base register read-back |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request ready |
| h_req_write | input | 1 | 1 = write, 0 = read |
| h_req_lock | input | 1 | Locked access |
| h_req_size | input | 2 | Access size code, log2 of the byte count |
| h_req_addr | input | 32 | Host byte address |
| h_req_be | input | 4 | Byte enables within the dword |
| h_req_wdata | input | 32 | Host write data |
| mem_req_valid | output | 1 | Request steered to the memory path |
| mem_req_ready | input | 1 | Memory path ready |
| c_req_valid | output | 1 | Configuration request valid |
| c_req_ready | input | 1 | Configuration request accepted |
| c_req_write | output | 1 | Configuration write |
| c_req_bus | output | 8 | Target bus number |
| c_req_dev | output | 5 | Target device number |
| c_req_fn | output | 3 | Target function number |
| c_req_ext | output | 4 | Extended register number |
| c_req_dw | output | 6 | Dword register number |
| c_req_be | output | 4 | Byte enables |
| c_req_wdata | output | 32 | Write data |
| c_cpl_valid | input | 1 | Completion valid |
| c_cpl_data | input | 32 | Completion data |
| c_cpl_err | input | 1 | Completion error |
| h_rsp_valid | output | 1 | Host response pulse |
| h_rsp_err | output | 1 | Host response error |
| h_rsp_data | output | 32 | Host response data |

## Verification
The translator is driven with five kinds of address:
- in-window offsets at both edges of the legacy region and the first and last dwords of the extended region, which show where the extended field switches from zero to non-zero;
- the highest bus, device and function number together with an irregular mid-range pattern, which show that no field is shifted or truncated;
- addresses just below and above the window and an address with the window disabled, which separate the hit test from the enable bit;
- misaligned, eight-byte and locked hits, each of which must be rejected without reaching the downstream channel;
- completions arriving after a stalled request handshake and carrying an error, which show that the single-outstanding hold and the return of the status work.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  // Size of the configuration window: one 256 MB region.
  localparam int WIN_LOG2 = 28;
  // Field widths of the outgoing configuration address.
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int EXT_W = 4;
  localparam int DW_W  = 6;
  localparam int SZ_W  = 2;
  // Size code 3 (eight bytes) is wider than one dword.
  localparam logic [SZ_W-1:0] SZ_WIDE = 2'd3;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [EXT_W-1:0] ext;
    logic [DW_W-1:0]  dw;
  } cfg_tgt_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_t;
endpackage

// File: rtl/cfgx_base_reg.sv
module cfgx_base_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-cfgx_pkg::WIN_LOG2-1:0] base,
  output logic              en
);
  localparam int BASE_W = ADDR_W - cfgx_pkg::WIN_LOG2;
  // Only the window base bits and the enable bit can be written.
  localparam logic [ADDR_W-1:0] WR_MASK = {{BASE_W{1'b1}}, {(ADDR_W-BASE_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)        held_q <= '0;
    else if (wr_en) held_q <= wdata & WR_MASK;
  end

  assign rdata = held_q;
  assign base  = held_q[ADDR_W-1 -: BASE_W];
  assign en    = held_q[0];
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [cfgx_pkg::SZ_W-1:0] size,
  input  logic              lock,
  input  logic [ADDR_W-cfgx_pkg::WIN_LOG2-1:0] base,
  input  logic              en,
  output logic              hit,
  output logic              illegal,
  output cfgx_pkg::cfg_tgt_t tgt
);
  import cfgx_pkg::*;
  localparam int BASE_W = ADDR_W - WIN_LOG2;
  // Bit positions of the fields, from the top of the window offset downward.
  localparam int BUS_HI = WIN_LOG2 - 1;
  localparam int DEV_HI = BUS_HI - BUS_W;
  localparam int FN_HI  = DEV_HI - DEV_W;
  localparam int EXT_HI = FN_HI - FN_W;
  localparam int DW_HI  = EXT_HI - EXT_W;

  assign hit = en && (addr[ADDR_W-1 -: BASE_W] == base);

  assign tgt.bus = addr[BUS_HI -: BUS_W];
  assign tgt.dev = addr[DEV_HI -: DEV_W];
  assign tgt.fn  = addr[FN_HI  -: FN_W];
  assign tgt.ext = addr[EXT_HI -: EXT_W];
  assign tgt.dw  = addr[DW_HI  -: DW_W];

  // Misaligned, wider than a dword, or locked.
  assign illegal = (addr[1:0] != 2'b00) || (size == SZ_WIDE) || lock;
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_wdata,
  output logic [ADDR_W-1:0]   reg_rdata,
  input  logic                h_req_valid,
  output logic                h_req_ready,
  input  logic                h_req_write,
  input  logic                h_req_lock,
  input  logic [1:0]          h_req_size,
  input  logic [ADDR_W-1:0]   h_req_addr,
  input  logic [DATA_W/8-1:0] h_req_be,
  input  logic [DATA_W-1:0]   h_req_wdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                c_req_valid,
  input  logic                c_req_ready,
  output logic                c_req_write,
  output logic [7:0]          c_req_bus,
  output logic [4:0]          c_req_dev,
  output logic [2:0]          c_req_fn,
  output logic [3:0]          c_req_ext,
  output logic [5:0]          c_req_dw,
  output logic [DATA_W/8-1:0] c_req_be,
  output logic [DATA_W-1:0]   c_req_wdata,
  input  logic                c_cpl_valid,
  input  logic [DATA_W-1:0]   c_cpl_data,
  input  logic                c_cpl_err,
  output logic                h_rsp_valid,
  output logic                h_rsp_err,
  output logic [DATA_W-1:0]   h_rsp_data
);
  import cfgx_pkg::*;
  localparam int BASE_W = ADDR_W - WIN_LOG2;
  localparam int BE_W   = DATA_W / 8;

  logic [BASE_W-1:0] win_base;
  logic              win_en;
  logic              win_hit;
  logic              req_bad;
  cfg_tgt_t          tgt_d;
  cfg_tgt_t          tgt_q;
  xl_state_t         st;
  logic              take;

  cfgx_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk   (clk),
    .rst   (rst),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .base  (win_base),
    .en    (win_en)
  );

  cfgx_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (h_req_addr),
    .size    (h_req_size),
    .lock    (h_req_lock),
    .base    (win_base),
    .en      (win_en),
    .hit     (win_hit),
    .illegal (req_bad),
    .tgt     (tgt_d)
  );

  // Misses are steered straight to the memory path.
  assign mem_req_valid = h_req_valid && !win_hit;
  assign h_req_ready   = win_hit ? (st == ST_IDLE) : mem_req_ready;
  assign take          = h_req_valid && win_hit && (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      c_req_valid <= 1'b0;
      c_req_write <= 1'b0;
      c_req_be    <= '0;
      c_req_wdata <= '0;
      tgt_q       <= '0;
      h_rsp_valid <= 1'b0;
      h_rsp_err   <= 1'b0;
      h_rsp_data  <= '0;
    end else begin
      h_rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (take) begin
            if (req_bad) begin
              st          <= ST_RESP;
              h_rsp_valid <= 1'b1;
              h_rsp_err   <= 1'b1;
              h_rsp_data  <= '1;
            end else begin
              st          <= ST_ISSUE;
              c_req_valid <= 1'b1;
              c_req_write <= h_req_write;
              c_req_be    <= h_req_be;
              c_req_wdata <= h_req_wdata;
              tgt_q       <= tgt_d;
            end
          end
        end
        ST_ISSUE: begin
          if (c_req_ready) begin
            c_req_valid <= 1'b0;
            st          <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (c_cpl_valid) begin
            st          <= ST_RESP;
            h_rsp_valid <= 1'b1;
            h_rsp_err   <= c_cpl_err;
            h_rsp_data  <= c_cpl_data;
          end
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign c_req_bus = tgt_q.bus;
  assign c_req_dev = tgt_q.dev;
  assign c_req_fn  = tgt_q.fn;
  assign c_req_ext = tgt_q.ext;
  assign c_req_dw  = tgt_q.dw;

  logic [BE_W-1:0] unused_be_w;
  assign unused_be_w = '0;
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              h_req_valid,
  input logic              h_req_ready,
  input logic              h_req_lock,
  input logic [1:0]        h_req_size,
  input logic [ADDR_W-1:0] h_req_addr,
  input logic              win_hit,
  input logic              c_req_valid,
  input logic              c_req_ready,
  input logic [7:0]        c_req_bus,
  input logic [4:0]        c_req_dev,
  input logic [2:0]        c_req_fn,
  input logic [3:0]        c_req_ext,
  input logic [5:0]        c_req_dw,
  input logic              h_rsp_valid,
  input logic              h_rsp_err,
  input logic [DATA_W-1:0] h_rsp_data
);
  // R2
  cfg_from_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(c_req_valid) |-> $past(h_req_valid && win_hit && h_req_ready));

  // R6
  misalign_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (h_req_valid && h_req_ready && win_hit && h_req_addr[1:0] != 2'b00)
    |=> (h_rsp_valid && h_rsp_err && h_rsp_data == '1 && !c_req_valid));

  // R7
  wide_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (h_req_valid && h_req_ready && win_hit && h_req_size == 2'd3)
    |=> (h_rsp_valid && h_rsp_err && h_rsp_data == '1 && !c_req_valid));

  // R8
  lock_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (h_req_valid && h_req_ready && win_hit && h_req_lock)
    |=> (h_rsp_valid && h_rsp_err && h_rsp_data == '1 && !c_req_valid));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (c_req_valid && !c_req_ready)
    |=> (c_req_valid && $stable(c_req_bus) && $stable(c_req_dev) && $stable(c_req_fn)
         && $stable(c_req_ext) && $stable(c_req_dw)));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (c_req_valid && win_hit) |-> !h_req_ready);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    h_rsp_valid |=> !h_rsp_valid);
endmodule

bind cfg_window_xlate cfgx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .h_req_valid (h_req_valid),
  .h_req_ready (h_req_ready),
  .h_req_lock  (h_req_lock),
  .h_req_size  (h_req_size),
  .h_req_addr  (h_req_addr),
  .win_hit     (win_hit),
  .c_req_valid (c_req_valid),
  .c_req_ready (c_req_ready),
  .c_req_bus   (c_req_bus),
  .c_req_dev   (c_req_dev),
  .c_req_fn    (c_req_fn),
  .c_req_ext   (c_req_ext),
  .c_req_dw    (c_req_dw),
  .h_rsp_valid (h_rsp_valid),
  .h_rsp_err   (h_rsp_err),
  .h_rsp_data  (h_rsp_data)
);

// File: tb/cfg_window_xlate_bench.sv
module cfg_window_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        h_req_valid = 1'b0;
  logic        h_req_ready;
  logic        h_req_write = 1'b0;
  logic        h_req_lock = 1'b0;
  logic [1:0]  h_req_size = 2'd2;
  logic [31:0] h_req_addr = '0;
  logic [3:0]  h_req_be = '0;
  logic [31:0] h_req_wdata = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        c_req_valid;
  logic        c_req_ready = 1'b0;
  logic        c_req_write;
  logic [7:0]  c_req_bus;
  logic [4:0]  c_req_dev;
  logic [2:0]  c_req_fn;
  logic [3:0]  c_req_ext;
  logic [5:0]  c_req_dw;
  logic [3:0]  c_req_be;
  logic [31:0] c_req_wdata;
  logic        c_cpl_valid = 1'b0;
  logic [31:0] c_cpl_data = '0;
  logic        c_cpl_err = 1'b0;
  logic        h_rsp_valid;
  logic        h_rsp_err;
  logic [31:0] h_rsp_data;

  int n_checks = 0;
  int n_fail   = 0;
  // Reference model state.
  int  mdl_base = 0;
  bit  mdl_en   = 1'b0;
  bit  exp_creq = 1'b0;
  bit  exp_rsp  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_xlate u_cfg_window_xlate (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock; the model's per-cycle expectations are compared after it.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R9 c_req_valid per-cycle", {31'b0, c_req_valid}, {31'b0, exp_creq});
    chk("R10 h_rsp_valid per-cycle", {31'b0, h_rsp_valid}, {31'b0, exp_rsp});
  endtask

  task automatic reg_write(input logic [31:0] v);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    tick();
    reg_wr_en = 1'b0;
    mdl_base = int'(v[31:28]);
    mdl_en   = v[0];
    chk("R1 base readback", reg_rdata, {v[31:28], 27'b0, v[0]});
  endtask

  task automatic access(input string tag, input bit wr, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [3:0] be, input logic [1:0] sz,
                        input bit lk, input int rdy_wait, input int cpl_wait,
                        input logic [31:0] cd, input bit ce);
    bit hit;
    bit bad;
    hit = mdl_en && (int'(addr[31:28]) == mdl_base);
    bad = (addr[1:0] != 2'b00) || (sz == 2'd3) || lk;
    h_req_write = wr; h_req_addr = addr; h_req_wdata = wd; h_req_be = be;
    h_req_size = sz; h_req_lock = lk; h_req_valid = 1'b1;
    if (!hit) begin
      #1;
      chk({tag, " R2 mem_req_valid"}, {31'b0, mem_req_valid}, 32'd1);
      chk({tag, " R2 ready follows memory"}, {31'b0, h_req_ready}, {31'b0, mem_req_ready});
      tick();
      h_req_valid = 1'b0;
      tick();
      return;
    end
    if (bad) begin
      exp_rsp = 1'b1;
      tick();
      h_req_valid = 1'b0;
      chk({tag, " error flag"}, {31'b0, h_rsp_err}, 32'd1);
      chk({tag, " error data"}, h_rsp_data, 32'hFFFF_FFFF);
      exp_rsp = 1'b0;
      tick();
      chk({tag, " R9 ready after error"}, {31'b0, h_req_ready}, 32'd1);
      return;
    end
    exp_creq = 1'b1;
    tick();
    h_req_valid = 1'b0;
    chk({tag, " R3 bus"}, {24'b0, c_req_bus}, (addr >> 20) & 32'hFF);
    chk({tag, " R3 dev"}, {27'b0, c_req_dev}, (addr >> 15) & 32'h1F);
    chk({tag, " R3 fn"},  {29'b0, c_req_fn},  (addr >> 12) & 32'h7);
    chk({tag, " R4 ext"}, {28'b0, c_req_ext}, (addr >> 8) & 32'hF);
    chk({tag, " R3 dw"},  {26'b0, c_req_dw},  (addr >> 2) & 32'h3F);
    chk({tag, " R5 write"}, {31'b0, c_req_write}, {31'b0, wr});
    chk({tag, " R5 be"}, {28'b0, c_req_be}, {28'b0, be});
    chk({tag, " R5 wdata"}, c_req_wdata, wd);
    for (int i = 0; i < rdy_wait; i++) begin
      chk({tag, " R9 host held"}, {31'b0, h_req_ready}, 32'd0);
      tick();
      chk({tag, " R9 bus stable"}, {24'b0, c_req_bus}, (addr >> 20) & 32'hFF);
    end
    c_req_ready = 1'b1;
    exp_creq = 1'b0;
    tick();
    c_req_ready = 1'b0;
    for (int i = 0; i < cpl_wait; i++) begin
      chk({tag, " R9 host held in wait"}, {31'b0, h_req_ready}, 32'd0);
      tick();
    end
    c_cpl_valid = 1'b1; c_cpl_data = cd; c_cpl_err = ce;
    exp_rsp = 1'b1;
    tick();
    c_cpl_valid = 1'b0;
    chk({tag, " R10 data"}, h_rsp_data, cd);
    chk({tag, " R10 err"}, {31'b0, h_rsp_err}, {31'b0, ce});
    chk({tag, " R9 held in response"}, {31'b0, h_req_ready}, 32'd0);
    exp_rsp = 1'b0;
    tick();
    chk({tag, " R9 ready again"}, {31'b0, h_req_ready}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();
    chk("R1 reset readback", reg_rdata, 32'h0);
    // Window disabled: base 0 is not decoded.
    access("disabled", 1'b0, 32'h0000_0000, 32'h0, 4'hF, 2'd2, 1'b0, 0, 0, 32'h0, 1'b0);
    reg_write(32'hE123_4567);
    // Legacy region edges.
    access("off000", 1'b0, 32'hE000_0000, 32'h0, 4'hF, 2'd2, 1'b0, 0, 1, 32'h1234_5678, 1'b0);
    access("off0FC", 1'b1, 32'hE000_00FC, 32'hA5A5_5A5A, 4'b0101, 2'd2, 1'b0, 2, 0, 32'h0, 1'b0);
    // Extended region edges.
    access("off100", 1'b0, 32'hE000_0100, 32'h0, 4'hF, 2'd2, 1'b0, 1, 3, 32'hCAFE_0100, 1'b0);
    access("offFFC", 1'b1, 32'hE000_0FFC, 32'h0BAD_F00D, 4'b1000, 2'd2, 1'b0, 0, 0, 32'h0, 1'b0);
    // Highest bus/device/function, and a mixed pattern.
    access("maxbdf", 1'b0, 32'hEFFF_FFFC, 32'h0, 4'hF, 2'd2, 1'b0, 0, 2, 32'h8765_4321, 1'b0);
    access("mixed", 1'b1, 32'hE5A9_D7B0, 32'h1357_9BDF, 4'b0011, 2'd1, 1'b0, 1, 1, 32'h0, 1'b0);
    // Completion carrying an error (R10).
    access("cplerr", 1'b0, 32'hE010_8204, 32'h0, 4'hF, 2'd2, 1'b0, 0, 0, 32'hDEAD_BEEF, 1'b1);
    // Neighbouring windows pass through (R2).
    access("below", 1'b0, 32'hDFFF_FFFC, 32'h0, 4'hF, 2'd2, 1'b0, 0, 0, 32'h0, 1'b0);
    mem_req_ready = 1'b0;
    access("above", 1'b1, 32'hF000_0000, 32'h1, 4'hF, 2'd2, 1'b1, 0, 0, 32'h0, 1'b0);
    mem_req_ready = 1'b1;
    // Illegal hits.
    access("R6 misaligned", 1'b0, 32'hE000_0102, 32'h0, 4'hF, 2'd2, 1'b0, 0, 0, 32'h0, 1'b0);
    access("R7 wide", 1'b1, 32'hE000_0040, 32'h55, 4'hF, 2'd3, 1'b0, 0, 0, 32'h0, 1'b0);
    access("R8 locked", 1'b0, 32'hE000_0040, 32'h0, 4'hF, 2'd2, 1'b1, 0, 0, 32'h0, 1'b0);
    // A legal access still works after the errors.
    access("after", 1'b0, 32'hE000_0040, 32'h0, 4'hF, 2'd2, 1'b0, 0, 0, 32'h600D_600D, 1'b0);
    // Disable the window again.
    reg_write(32'hE000_0000);
    access("R2 redisabled", 1'b0, 32'hE000_0000, 32'h0, 4'hF, 2'd2, 1'b0, 0, 0, 32'h0, 1'b0);
    tick();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule